// File: doc/BRIEF.md
# LDPC Early-Stop Monitor for Undecodable Codewords

This block sits beside an iterative LDPC decoder and decides when decoding of the current codeword should stop. At the end of every iteration the decoder pulses a strobe and presents the checksum: the number of parity checks still unsatisfied. The monitor counts iterations itself. It keeps the checksums that fall inside a three-iteration observation window, and it tests them against three fixed thresholds, one for each window slot.

A codeword whose checksum does not fall steadily through the window is treated as hopeless. So is one whose checksums all sit above their thresholds. In either case the block raises a one-cycle undecodable pulse, so the decoder can stop spending energy on it. A checksum of zero raises a converged pulse. Reaching the iteration limit without either outcome raises a limit pulse. Every verdict also pulses a common terminate output. After a verdict the monitor ignores strobes until a start pulse opens the next codeword. The test needs only a history register pair and a few comparators, and it uses no channel quality estimate.

Top module: `ldpc_stop_monitor`

## Requirements
- R1: After reset, converged_o, undecodable_o, max_iter_o and terminate_o are 0 and iter_o is 0.
- R2: Each accepted strobe (valid_i high, start_i low, no verdict yet for this codeword) raises iter_o by one, visible after the next clock edge; start_i returns iter_o to 0 and wins over a strobe in the same cycle.
- R3: An accepted strobe with checksum_i equal to 0 gives converged_o = 1 and terminate_o = 1 in the following cycle.
- R4: At the strobe for iteration WIN_START+2 (iterations are numbered from 1), undecodable_o pulses when all three conditions hold: the iteration WIN_START checksum is strictly above TH1, the iteration WIN_START+1 checksum is strictly above TH2, and the current checksum is strictly above TH3. A value equal to its threshold does not count as above.
- R5: At the same strobe, undecodable_o also pulses when the three window checksums are not strictly decreasing, whatever their size.
- R6: A zero checksum gives converged_o and never undecodable_o or max_iter_o, even at the window end or at the iteration limit.
- R7: An accepted strobe for iteration MAX_ITER with a non-zero checksum and no undecodable verdict gives max_iter_o = 1.
- R8: After any verdict, further strobes cause no flag and leave iter_o unchanged until start_i.
- R9: Each flag is high for exactly one cycle, at most one of converged_o, undecodable_o and max_iter_o is high at a time, and terminate_o is high exactly when one of them is.
- R10: Checksums of iterations outside the window never cause undecodable_o, even when they rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start of a new codeword; clears history and iteration count |
| valid_i | input | 1 | One pulse per finished decoder iteration |
| checksum_i | input | CW | Unsatisfied parity check count for that iteration |
| iter_o | output | IW | Number of iterations accepted for the current codeword |
| converged_o | output | 1 | Pulse: checksum reached zero |
| undecodable_o | output | 1 | Pulse: window test failed, codeword abandoned |
| max_iter_o | output | 1 | Pulse: iteration limit reached without convergence |
| terminate_o | output | 1 | Pulse: any of the three verdicts |

## Verification
The bench builds the monitor with 384 check rows and thresholds of 110, 105 and 100. It places the window at iterations 3 to 5 and lowers the iteration limit to 8. Both window verdicts and the limit verdict are therefore reached with short codewords of a handful of strobes. The bench also covers values exactly at each threshold and one above, and a codeword that rises before the window opens. A zero checksum landing on the window-end iteration shows that convergence takes priority.

// File: rtl/stop_pkg.sv
package stop_pkg;
  typedef enum logic [1:0] {
    VERD_NONE  = 2'd0,
    VERD_CONV  = 2'd1,
    VERD_UNDEC = 2'd2,
    VERD_MAX   = 2'd3
  } verdict_e;
endpackage

// File: rtl/stop_iter_ctr.sv
module stop_iter_ctr #(
  parameter int MAX_ITER  = 16,
  parameter int WIN_START = 4,
  parameter int IW        = $clog2(MAX_ITER + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          valid_i,
  input  logic          term_i,
  output logic [IW-1:0] iter_o,
  output logic          accept_o,
  output logic          done_o,
  output logic [2:0]    win_o,
  output logic          last_o
);
  logic [IW-1:0] iter_q, iter_nxt;
  logic          done_q;

  assign accept_o = valid_i & ~start_i & ~done_q;
  assign iter_nxt = iter_q + 1'b1;   // number of the iteration being reported

  for (genvar g = 0; g < 3; g++) begin : g_win
    assign win_o[g] = (iter_nxt == IW'(WIN_START + g));
  end

  assign last_o = (iter_nxt == IW'(MAX_ITER));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iter_q <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      iter_q <= '0;
      done_q <= 1'b0;
    end else if (accept_o) begin
      iter_q <= iter_nxt;
      if (term_i) done_q <= 1'b1;
    end
  end

  assign iter_o = iter_q;
  assign done_o = done_q;

  a_r2_iter_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> iter_q == IW'($past(iter_q) + 1'b1));
  a_r2_start_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> iter_q == '0);
  a_r8_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !start_i) |=> $stable(iter_q));
endmodule

// File: rtl/stop_hist.sv
module stop_hist #(
  parameter int CW    = 9,
  parameter int DEPTH = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     accept_i,
  input  logic [DEPTH-1:0]         slot_i,
  input  logic [CW-1:0]            checksum_i,
  output logic [DEPTH-1:0][CW-1:0] hist_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [CW-1:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       val_q <= '0;
      else if (start_i)                  val_q <= '0;
      else if (accept_i && slot_i[g])    val_q <= checksum_i;
    end
    assign hist_o[g] = val_q;
  end
endmodule

// File: rtl/stop_decide.sv
module stop_decide
  import stop_pkg::*;
#(
  parameter int CW  = 9,
  parameter int TH1 = 110,
  parameter int TH2 = 105,
  parameter int TH3 = 100
) (
  input  logic          accept_i,
  input  logic          win_end_i,
  input  logic          last_i,
  input  logic [CW-1:0] first_i,
  input  logic [CW-1:0] second_i,
  input  logic [CW-1:0] cur_i,
  output verdict_e      verdict_o
);
  localparam logic [CW-1:0] T1 = CW'(TH1);
  localparam logic [CW-1:0] T2 = CW'(TH2);
  localparam logic [CW-1:0] T3 = CW'(TH3);

  logic all_high, falling;

  assign all_high = (first_i > T1) && (second_i > T2) && (cur_i > T3);
  assign falling  = (second_i < first_i) && (cur_i < second_i);

  // priority: converged, undecodable, iteration limit
  always_comb begin
    verdict_o = VERD_NONE;
    if (accept_i) begin
      if (cur_i == '0)                           verdict_o = VERD_CONV;
      else if (win_end_i && (all_high || !falling)) verdict_o = VERD_UNDEC;
      else if (last_i)                           verdict_o = VERD_MAX;
    end
  end
endmodule

// File: rtl/ldpc_stop_monitor.sv
module ldpc_stop_monitor
  import stop_pkg::*;
#(
  parameter int N_CHECKS  = 384,
  parameter int MAX_ITER  = 16,
  parameter int WIN_START = 4,
  parameter int TH1       = 110,
  parameter int TH2       = 105,
  parameter int TH3       = 100,
  localparam int CW       = $clog2(N_CHECKS + 1),
  localparam int IW       = $clog2(MAX_ITER + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          valid_i,
  input  logic [CW-1:0] checksum_i,
  output logic [IW-1:0] iter_o,
  output logic          converged_o,
  output logic          undecodable_o,
  output logic          max_iter_o,
  output logic          terminate_o
);
  logic                  accept, done, last;
  logic [2:0]            win;
  logic [1:0][CW-1:0]    hist;
  verdict_e              verdict;
  logic                  term;
  logic                  conv_q, undec_q, max_q;

  assign term = (verdict != VERD_NONE);

  stop_iter_ctr #(.MAX_ITER(MAX_ITER), .WIN_START(WIN_START), .IW(IW)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .valid_i(valid_i),
    .term_i(term), .iter_o(iter_o), .accept_o(accept), .done_o(done),
    .win_o(win), .last_o(last)
  );

  stop_hist #(.CW(CW), .DEPTH(2)) u_hist (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .accept_i(accept),
    .slot_i(win[1:0]), .checksum_i(checksum_i), .hist_o(hist)
  );

  stop_decide #(.CW(CW), .TH1(TH1), .TH2(TH2), .TH3(TH3)) u_dec (
    .accept_i(accept), .win_end_i(win[2]), .last_i(last),
    .first_i(hist[0]), .second_i(hist[1]), .cur_i(checksum_i),
    .verdict_o(verdict)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conv_q  <= 1'b0;
      undec_q <= 1'b0;
      max_q   <= 1'b0;
    end else begin
      conv_q  <= (verdict == VERD_CONV);
      undec_q <= (verdict == VERD_UNDEC);
      max_q   <= (verdict == VERD_MAX);
    end
  end

  assign converged_o   = conv_q;
  assign undecodable_o = undec_q;
  assign max_iter_o    = max_q;
  assign terminate_o   = conv_q | undec_q | max_q;

  a_r3_zero_converges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !start_i && !done && checksum_i == '0) |=> converged_o);
  a_r4_undec_at_window_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undecodable_o |-> iter_o == IW'(WIN_START + 2));
  a_r7_max_at_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    max_iter_o |-> iter_o == IW'(MAX_ITER));
  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({converged_o, undecodable_o, max_iter_o}));
  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    terminate_o |=> !terminate_o);
  a_r8_quiet_after_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !start_i) |=> !terminate_o);
endmodule

// File: tb/ldpc_stop_monitor_test.sv
module ldpc_stop_monitor_test;
  localparam int NCHK = 384, MAXI = 8, WS = 3;
  localparam int T1 = 110, T2 = 105, T3 = 100;
  localparam int CW = $clog2(NCHK + 1), IW = $clog2(MAXI + 1);

  typedef struct {
    bit    conv, undec, maxi;
    int    iter;
    string tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, valid = 1'b0;
  logic [CW-1:0] csum = '0;
  logic [IW-1:0] iter;
  logic conv, undec, maxi, term;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  int m_cnt = 0;
  bit m_done = 1'b0;
  int m_hist[3];

  always #5 clk = ~clk;

  ldpc_stop_monitor #(.N_CHECKS(NCHK), .MAX_ITER(MAXI), .WIN_START(WS),
    .TH1(T1), .TH2(T2), .TH3(T3)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .valid_i(valid),
    .checksum_i(csum), .iter_o(iter), .converged_o(conv),
    .undecodable_o(undec), .max_iter_o(maxi), .terminate_o(term));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input int c, input string tag);
    exp_t e;
    int k;
    @(negedge clk);
    valid = 1'b1;
    csum  = CW'(c);
    e.conv = 0; e.undec = 0; e.maxi = 0; e.tag = tag;
    if (!m_done) begin
      k = m_cnt + 1;
      if (k >= WS && k <= WS + 2) m_hist[k - WS] = c;
      if (c == 0) e.conv = 1;
      else if (k == WS + 2 &&
               ((m_hist[0] > T1 && m_hist[1] > T2 && c > T3) ||
                !(m_hist[1] < m_hist[0] && c < m_hist[1]))) e.undec = 1;
      else if (k == MAXI) e.maxi = 1;
      m_cnt = k;
      if (e.conv || e.undec || e.maxi) m_done = 1'b1;
    end
    e.iter = m_cnt;
    q.push_back(e);
    @(negedge clk);
    valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic begin_cw();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    m_cnt = 0; m_done = 1'b0;
    chk(iter == '0, "R2 start clears count", int'(iter), 0);
  endtask

  // monitor: one expected item per strobe
  initial begin
    exp_t e;
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      if (valid && !start) begin
        @(negedge clk);
        e = q.pop_front();
        chk(conv  == e.conv,  {e.tag, " converged_o"},   int'(conv),  int'(e.conv));
        chk(undec == e.undec, {e.tag, " undecodable_o"}, int'(undec), int'(e.undec));
        chk(maxi  == e.maxi,  {e.tag, " max_iter_o"},    int'(maxi),  int'(e.maxi));
        chk(term  == (e.conv | e.undec | e.maxi), {e.tag, " R9 terminate_o"},
            int'(term), int'(e.conv | e.undec | e.maxi));
        chk(int'(iter) == e.iter, {e.tag, " iter_o"}, int'(iter), e.iter);
        @(posedge clk);
        @(negedge clk);
        chk({conv, undec, maxi, term} == 4'b0, "R9 pulse lasts one cycle",
            int'({conv, undec, maxi, term}), 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1;
    chk({conv, undec, maxi, term} == 4'b0, "R1 flags in reset", int'({conv, undec, maxi, term}), 0);
    chk(iter == '0, "R1 count in reset", int'(iter), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({conv, undec, maxi, term} == 4'b0, "R1 flags after reset", int'({conv, undec, maxi, term}), 0);

    // early convergence, then ignored strobes
    begin_cw();
    send(300, "R2"); send(250, "R2"); send(0, "R3");
    send(50, "R8"); send(0, "R8");

    // all window values above thresholds, still falling
    begin_cw();
    send(200, "R2"); send(190, "R2"); send(180, "R4"); send(170, "R4"); send(160, "R4");
    send(10, "R8");

    // below thresholds but not strictly falling
    begin_cw();
    send(90, "R2"); send(80, "R2"); send(60, "R5"); send(60, "R5"); send(50, "R5");

    // rise before window, clean window, then limit
    begin_cw();
    send(50, "R10"); send(90, "R10"); send(80, "R10"); send(40, "R10"); send(20, "R10");
    send(15, "R7"); send(10, "R7"); send(5, "R7"); send(3, "R8");

    // zero on window-end iteration
    begin_cw();
    send(200, "R6"); send(200, "R6"); send(200, "R6"); send(200, "R6"); send(0, "R6");

    // start mid-codeword, restart counting
    begin_cw();
    send(384, "R2"); send(384, "R2");
    begin_cw();
    send(384, "R2"); send(0, "R3");

    // values exactly at thresholds: no verdict, then limit
    begin_cw();
    send(300, "R4"); send(200, "R4"); send(110, "R4"); send(105, "R4"); send(100, "R4");
    send(90, "R7"); send(80, "R7"); send(70, "R7");

    // one above each threshold
    begin_cw();
    send(300, "R4"); send(200, "R4"); send(111, "R4"); send(106, "R4"); send(101, "R4");

    // zero on the limit iteration
    begin_cw();
    send(200, "R6"); send(150, "R6"); send(100, "R6"); send(80, "R6"); send(60, "R6");
    send(40, "R6"); send(20, "R6"); send(0, "R6");

    // strobe coincident with start is dropped
    @(negedge clk);
    start = 1'b1; valid = 1'b1; csum = '0;
    @(negedge clk);
    start = 1'b0; valid = 1'b0;
    m_cnt = 0; m_done = 1'b0;
    chk(iter == '0, "R2 start wins over strobe", int'(iter), 0);
    chk(conv == 1'b0, "R2 start wins over strobe", int'(conv), 0);

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R9 all strobes observed", q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule